// File: doc/BRIEF.md
# Decimating Instruction-Trace Forwarder

This block sits beside the path between a processor and its first-level instruction cache and passes a thinned copy of the fetch stream to an external checker over a slower link. Every fetch advances a phase counter that cycles from 1 up to a runtime ratio K. A regular instruction goes out only when the phase reads 1. A word flagged as a signature (a block header or a successor label) always goes out. The ratio K is chosen as the fetch-path bandwidth over the link bandwidth, each bandwidth taken as clock rate times bus width times transfers per clock. The checker needs every signature to follow the block sequence.

The phase counter spans the whole program and is never realigned to block boundaries. A loop whose length is coprime with K therefore exposes a different subset of its words on each pass. A program-start pulse returns the phase to 1. The forwarded traffic runs slightly above one word in K, so a small first-in first-out buffer absorbs short bursts. The buffer drains through a valid/ready output. A forwarded word that finds the buffer full is dropped, and a sticky overflow flag records the loss.

Top module: `trace_fwd`

## Requirements
- R1: After reset, out_valid_o and overflow_o are 0 and the phase is 1, so the first fetch is forwarded.
- R2: Each accepted fetch (fetch_valid_i high) advances the phase 1,2,...,K,1,... A regular fetch (fetch_sig_i=0) is forwarded only when the phase is 1, so with K=3 the fetches numbered 0,3,6 after a start are forwarded.
- R3: A fetch with fetch_sig_i=1 is always forwarded with out_sig_o=1, and it also advances the phase.
- R4: The phase holds across cycles with fetch_valid_i low and is never realigned except by start_i.
- R5: start_i sets the phase to 1. A fetch in the same cycle as start_i is treated as phase 1 and forwarded.
- R6: With k_i equal to 0 or 1, every fetch is forwarded.
- R7: Forwarded entries leave in fetch order with their address, data and signature flag intact.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o and the payload stay stable.
- R9: A forwarded fetch that arrives while the buffer holds DEPTH entries and no pop happens is dropped, and overflow_o is set. overflow_o stays set until a start_i cycle with no drop. A pop in the same cycle makes room, so the fetch is accepted.
- R10: With the buffer empty, a forwarded fetch appears on out_valid_o in the cycle after the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Program-start pulse; sets the phase to 1 and clears overflow |
| k_i | input | KW | Decimation ratio K |
| fetch_valid_i | input | 1 | A fetch is present this cycle |
| fetch_sig_i | input | 1 | The fetched word is a signature |
| fetch_addr_i | input | 32 | Fetch address |
| fetch_data_i | input | 32 | Fetched word |
| out_valid_o | output | 1 | Buffer head is valid |
| out_ready_i | input | 1 | External link accepts the head |
| out_addr_o | output | 32 | Head address |
| out_data_o | output | 32 | Head word |
| out_sig_o | output | 1 | Head is a signature |
| overflow_o | output | 1 | Sticky: a forwarded word was dropped |

## Verification
The hardest situation to reach is a forwarded fetch that meets a full buffer. It is hardest when that fetch coincides with a pop, because the entry must then be accepted and not dropped. The bench holds out_ready_i low with K=1 so that every fetch fills a slot. It drives two fetches past capacity to force drops. After a start pulse it refills the buffer and raises out_ready_i in the same cycle as one more fetch. The phase sequences are checked by comparing the drained stream with a list of expected entries. That list is built from fetch numbering, with mixed signatures and idle gaps and restarts in the middle of a run.

// File: rtl/trace_fwd_pkg.sv
package trace_fwd_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic              sig;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } entry_t;

  localparam int unsigned ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/trace_fwd_phase.sv
module trace_fwd_phase #(
  parameter int unsigned KW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          step_i,
  input  logic          sig_i,
  input  logic [KW-1:0] k_i,
  output logic          sel_o
);
  localparam logic [KW-1:0] ONE = KW'(1);

  logic [KW-1:0] cnt_q, cur, nxt;

  // start aligns the current fetch to phase 1
  assign cur = start_i ? ONE : cnt_q;
  // >= also recovers when K shrinks below the current phase
  assign nxt = (cur >= k_i) ? ONE : cur + ONE;
  assign sel_o = step_i && (sig_i || cur == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= ONE;
    else if (step_i)  cnt_q <= nxt;
    else if (start_i) cnt_q <= ONE;
  end
endmodule

// File: rtl/trace_fwd_fifo.sv
module trace_fwd_fifo #(
  parameter int unsigned W     = 65,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         valid_o,
  output logic         drop_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_pop, do_push;

  assign full    = (cnt_q == FULL_CNT);
  assign valid_o = (cnt_q != '0);
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && (!full || do_pop);
  assign drop_o  = push_i && full && !do_pop;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + PW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (do_push && wr_q == PW'(g))      mem_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/trace_fwd.sv
module trace_fwd #(
  parameter int unsigned KW    = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [KW-1:0]                      k_i,
  input  logic                               fetch_valid_i,
  input  logic                               fetch_sig_i,
  input  logic [trace_fwd_pkg::ADDR_W-1:0]   fetch_addr_i,
  input  logic [trace_fwd_pkg::DATA_W-1:0]   fetch_data_i,
  output logic                               out_valid_o,
  input  logic                               out_ready_i,
  output logic [trace_fwd_pkg::ADDR_W-1:0]   out_addr_o,
  output logic [trace_fwd_pkg::DATA_W-1:0]   out_data_o,
  output logic                               out_sig_o,
  output logic                               overflow_o
);
  import trace_fwd_pkg::*;

  logic   sel, drop, ovf_q;
  entry_t wr_e, rd_e;

  trace_fwd_phase #(.KW(KW)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .step_i  (fetch_valid_i),
    .sig_i   (fetch_sig_i),
    .k_i     (k_i),
    .sel_o   (sel)
  );

  assign wr_e = '{sig: fetch_sig_i, addr: fetch_addr_i, data: fetch_data_i};

  trace_fwd_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sel),
    .wdata_i (wr_e),
    .pop_i   (out_ready_i),
    .rdata_o (rd_e),
    .valid_o (out_valid_o),
    .drop_o  (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovf_q <= 1'b0;
    else if (drop)    ovf_q <= 1'b1;
    else if (start_i) ovf_q <= 1'b0;
  end

  assign overflow_o = ovf_q;
  assign out_addr_o = rd_e.addr;
  assign out_data_o = rd_e.data;
  assign out_sig_o  = rd_e.sig;
endmodule

// File: rtl/trace_fwd_chk.sv
module trace_fwd_chk #(
  parameter int unsigned KW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [KW-1:0] k_i,
  input logic          fetch_valid_i,
  input logic          fetch_sig_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [31:0]   out_addr_o,
  input logic [31:0]   out_data_o,
  input logic          out_sig_o,
  input logic          overflow_o
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o)
      && $stable(out_data_o) && $stable(out_sig_o));

  assert_sig_fwd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && fetch_sig_i && !out_valid_o |=> out_valid_o && out_sig_o);

  assert_start_fwd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && start_i && !out_valid_o |=> out_valid_o);

  assert_k_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && (k_i <= KW'(1)) && !out_valid_o |=> out_valid_o);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !start_i |=> overflow_o);

  assert_empty_ok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |=> !$rose(overflow_o));
endmodule

bind trace_fwd trace_fwd_chk #(.KW(KW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .k_i           (k_i),
  .fetch_valid_i (fetch_valid_i),
  .fetch_sig_i   (fetch_sig_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_addr_o    (out_addr_o),
  .out_data_o    (out_data_o),
  .out_sig_o     (out_sig_o),
  .overflow_o    (overflow_o)
);

// File: tb/trace_fwd_bench.sv
module trace_fwd_bench;
  import trace_fwd_pkg::*;

  localparam int unsigned KW    = 8;
  localparam int unsigned DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [KW-1:0] k_i = KW'(3);
  logic          fetch_valid_i = 1'b0;
  logic          fetch_sig_i = 1'b0;
  logic [31:0]   fetch_addr_i = '0;
  logic [31:0]   fetch_data_i = '0;
  logic          out_valid_o, out_ready_i = 1'b1, out_sig_o, overflow_o;
  logic [31:0]   out_addr_o, out_data_o;

  int n_chk = 0;
  int n_bad = 0;
  entry_t got_q[$];
  entry_t exp_q[$];

  always #4 clk = ~clk;

  trace_fwd #(.KW(KW), .DEPTH(DEPTH)) u_trace_fwd (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .k_i(k_i),
    .fetch_valid_i(fetch_valid_i), .fetch_sig_i(fetch_sig_i),
    .fetch_addr_i(fetch_addr_i), .fetch_data_i(fetch_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_addr_o(out_addr_o), .out_data_o(out_data_o),
    .out_sig_o(out_sig_o), .overflow_o(overflow_o)
  );

  // record every handshake, sampled mid-cycle
  always begin
    @(negedge clk);
    #2;
    if (rst_ni && out_valid_o && out_ready_i)
      got_q.push_back('{sig: out_sig_o, addr: out_addr_o, data: out_data_o});
  end

  function automatic logic [31:0] dat(input logic [31:0] a);
    return ~a ^ 32'h5a00_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input logic s, input logic st,
                       input bit fwd);
    @(negedge clk);
    fetch_valid_i = 1'b1;
    fetch_sig_i   = s;
    fetch_addr_i  = a;
    fetch_data_i  = dat(a);
    start_i       = st;
    if (fwd) exp_q.push_back('{sig: s, addr: a, data: dat(a)});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fetch_valid_i = 1'b0;
      start_i       = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    fetch_valid_i = 1'b0;
    start_i       = 1'b1;
    idle(1);
  endtask

  task automatic drain_cmp(input string req);
    idle(DEPTH + 4);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    #2;
    chk(out_valid_o == 1'b0, "R1 valid", out_valid_o, 0);
    chk(overflow_o == 1'b0, "R1 overflow", overflow_o, 0);
  endtask

  task automatic t_first_after_reset();
    k_i = KW'(3);
    for (int i = 0; i < 4; i++) fetch(32'h10 + 4 * i, 1'b0, 1'b0, i == 0 || i == 3);
    drain_cmp("R1 first fetch");
  endtask

  task automatic t_decimate();
    k_i = KW'(3);
    pulse_start();
    for (int i = 0; i < 9; i++) fetch(32'h100 + 4 * i, 1'b0, 1'b0, i % 3 == 0);
    drain_cmp("R2 K=3 decimation");
  endtask

  task automatic t_sig();
    bit is_sig [8] = '{0, 1, 0, 0, 0, 1, 0, 0};
    bit fwd    [8] = '{1, 1, 0, 0, 1, 1, 0, 0};
    k_i = KW'(4);
    pulse_start();
    for (int i = 0; i < 8; i++) fetch(32'h200 + 4 * i, is_sig[i], 1'b0, fwd[i]);
    drain_cmp("R3 signature bypass and advance");
  endtask

  task automatic t_noalign();
    k_i = KW'(3);
    pulse_start();
    for (int i = 0; i < 4; i++) fetch(32'h300 + 4 * i, 1'b0, 1'b0, i % 3 == 0);
    idle(5);
    for (int i = 4; i < 7; i++) fetch(32'h300 + 4 * i, 1'b0, 1'b0, i % 3 == 0);
    drain_cmp("R4 phase held over idle");
    // revisit same addresses: phase continues from 7 fetches (phase now 2)
    for (int i = 0; i < 4; i++) fetch(32'h300 + 4 * i, 1'b0, 1'b0, i == 2);
    drain_cmp("R4 no realign on revisit");
  endtask

  task automatic t_start_mid();
    k_i = KW'(3);
    pulse_start();
    fetch(32'h400, 1'b0, 1'b0, 1'b1);
    fetch(32'h404, 1'b0, 1'b0, 1'b0);
    fetch(32'h408, 1'b0, 1'b1, 1'b1);
    fetch(32'h40c, 1'b0, 1'b0, 1'b0);
    fetch(32'h410, 1'b0, 1'b0, 1'b0);
    fetch(32'h414, 1'b0, 1'b0, 1'b1);
    drain_cmp("R5 start with fetch");
  endtask

  task automatic t_k_low();
    k_i = KW'(1);
    pulse_start();
    for (int i = 0; i < 3; i++) fetch(32'h500 + 4 * i, 1'b0, 1'b0, 1'b1);
    drain_cmp("R6 K=1");
    k_i = KW'(0);
    for (int i = 0; i < 3; i++) fetch(32'h600 + 4 * i, 1'b0, 1'b0, 1'b1);
    drain_cmp("R6 K=0");
  endtask

  task automatic t_latency();
    k_i = KW'(1);
    pulse_start();
    fetch(32'h700, 1'b1, 1'b0, 1'b1);
    #2;
    chk(out_valid_o == 1'b0, "R10 not same cycle", out_valid_o, 0);
    idle(1);
    #2;
    chk(out_valid_o == 1'b1, "R10 next cycle valid", out_valid_o, 1);
    chk(out_addr_o == 32'h700 && out_sig_o, "R10 payload", out_addr_o, 32'h700);
    drain_cmp("R10 stream");
  endtask

  task automatic t_backpressure();
    k_i = KW'(1);
    pulse_start();
    @(negedge clk);
    out_ready_i = 1'b0;
    fetch(32'h800, 1'b0, 1'b0, 1'b1);
    fetch(32'h804, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      #2;
      chk(out_valid_o && out_addr_o == 32'h800 && out_data_o == dat(32'h800)
          && !out_sig_o, "R8 hold head", out_addr_o, 32'h800);
    end
    @(negedge clk);
    out_ready_i = 1'b1;
    drain_cmp("R7 order after stall");
  endtask

  task automatic t_overflow();
    k_i = KW'(1);
    pulse_start();
    @(negedge clk);
    out_ready_i = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++)
      fetch(32'h900 + 4 * i, 1'b0, 1'b0, i < DEPTH);
    idle(1);
    #2;
    chk(overflow_o == 1'b1, "R9 overflow set", overflow_o, 1);
    @(negedge clk);
    out_ready_i = 1'b1;
    drain_cmp("R9 dropped entries");
    chk(overflow_o == 1'b1, "R9 sticky", overflow_o, 1);
    pulse_start();
    #2;
    chk(overflow_o == 1'b0, "R9 cleared by start", overflow_o, 0);
    @(negedge clk);
    out_ready_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) fetch(32'ha00 + 4 * i, 1'b0, 1'b0, 1'b1);
    fetch(32'ha40, 1'b0, 1'b0, 1'b1);
    out_ready_i = 1'b1;
    idle(1);
    #2;
    chk(overflow_o == 1'b0, "R9 pop makes room", overflow_o, 0);
    drain_cmp("R9 full with pop");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    t_first_after_reset();
    t_decimate();
    t_sig();
    t_noalign();
    t_start_mid();
    t_k_low();
    t_latency();
    t_backpressure();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule